// File: doc/BRIEF.md
# Handshaked Shift-Register Packet Engine

This block is the device end of a byte-wide link to a host processor. Three active-low lines in an 8-bit port register carry the handshake: the host drives the transfer-in-progress line (TIP, bit 5) and the acknowledge line (TACK, bit 4), and the device drives the request line (TREQ, bit 3). Bytes travel through an 8-bit shift data register. A level input selects the direction. When it is 1, the host sends bytes to the device. When it is 0, the device sends bytes to the host.

In the host-to-device direction, each host write that changes the TIP/TACK pair captures the shift register into a byte buffer. When TIP returns high, a one-cycle packet-done strobe is raised, together with the captured length. In the device-to-host direction, a packet is first written into a second buffer and committed. Each handshake edge then loads the next byte into the shift register. The engine drives TREQ to ask for attention and to mark the last byte. Every byte event schedules a shift-register interrupt pulse. The pulse is delayed by a fixed time unless the port direction register holds all ones.

Top module: `hs_link_engine`

## Requirements
- R1: After reset the port register, shift register, packet length, packet-done strobe and interrupt output are all zero.
- R2: A host write to the port register appears on `pb_o`. TIP is bit 5, TACK is bit 4 and TREQ is bit 3, all active low. Only TREQ can differ from the written value, and only by the rules below.
- R3: While TIP is low and `shift_out_i` is 1, each port write that changes the TIP/TACK pair stores the current shift register into the next host-to-device slot and schedules an interrupt. A write that leaves the pair unchanged stores nothing and schedules nothing.
- R4: The host-to-device buffer holds DEPTH bytes (16 by default). Captures beyond DEPTH are dropped and schedule no interrupt.
- R5: A port write that takes TIP from low to high always schedules an interrupt. If at least one byte was captured, `pkt_done_o` pulses for one cycle, `hd_len_o` takes the count, and the capture index returns to zero. With no bytes captured there is no pulse.
- R6: While TIP is low and `shift_out_i` is 0, each TIP/TACK change with committed bytes remaining loads the next byte into the shift register and schedules an interrupt. Loading the last byte forces TREQ (bit 3) high. Once the packet is exhausted, further changes load nothing.
- R7: While TIP is high and was high before the write, a change of TACK sets TREQ equal to the new TACK value and schedules an interrupt. A write with no TACK change schedules nothing.
- R8: While TIP is high and committed bytes remain unsent, TREQ is forced low. This applies both at a commit and at a TIP low-to-high write.
- R9: A commit sets the packet length, returns the read index to zero so that the next load is byte 0, and schedules an interrupt.
- R10: A scheduled interrupt pulses `sr_irq_o` in the same cycle as the request edge when the direction register is 0xFF. Otherwise it pulses DELAY_CYC cycles later, where DELAY_CYC is CLK_HZ/1e6 times DELAY_US. A new delayed request restarts the wait, so an earlier pending pulse is dropped.
- R11: The direction register resets to 0xFF, so interrupts are immediate until software changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pb_wr_i | input | 1 | Host write strobe for the port register |
| pb_wdata_i | input | 8 | Port register write value |
| pb_o | output | 8 | Current port register, including TREQ |
| dirb_wr_i | input | 1 | Write strobe for the port direction register |
| dirb_wdata_i | input | 8 | Direction register write value |
| shift_out_i | input | 1 | 1: host-to-device bytes, 0: device-to-host bytes |
| sr_wr_i | input | 1 | Host write strobe for the shift register |
| sr_wdata_i | input | 8 | Shift register write value |
| sr_o | output | 8 | Current shift register |
| dh_wr_i | input | 1 | Write strobe into the device-to-host buffer |
| dh_waddr_i | input | AW | Device-to-host buffer write address |
| dh_wdata_i | input | 8 | Device-to-host buffer write byte |
| dh_commit_i | input | 1 | Queue a device-to-host packet |
| dh_len_i | input | CW | Length of the committed packet |
| hd_raddr_i | input | AW | Read address into the host-to-device buffer |
| hd_rdata_o | output | 8 | Byte at `hd_raddr_i` |
| hd_len_o | output | CW | Length of the last completed host-to-device packet |
| pkt_done_o | output | 1 | One-cycle strobe: host-to-device packet received |
| sr_irq_o | output | 1 | One-cycle shift-register interrupt pulse |

## Verification
The bench targets these corner cases:

- **Repeated port write with TIP/TACK unchanged.** A design that detected writes instead of pair changes would capture a duplicate byte and raise an extra interrupt.
- **Overrun past the buffer depth.** A design that got this wrong would wrap and overwrite byte 0, or report a length of 0 or 17.
- **Last device-to-host byte and a handshake edge after it.** A design that got this wrong would leave TREQ low or reload a stale byte.
- **TIP rising with bytes still queued.** A design that got this wrong would not force TREQ low.
- **Second commit.** A design that did not rewind would resume from the old read index.

Expected interrupt times are kept in a scoreboard queue. Closely spaced delayed requests must give a single pulse, timed from the last request. An immediate pulse after the direction register is set back to 0xFF must come in the request cycle.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
  localparam int TREQ_BIT = 3;
  localparam int TACK_BIT = 4;
  localparam int TIP_BIT  = 5;
  localparam logic [7:0] DIR_ALL_OUT = 8'hFF;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/hs_byte_ram.sv
module hs_byte_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/hs_irq_delay.sv
module hs_irq_delay
  import hs_link_pkg::*;
#(
  parameter int DELAY_CYC = 60000,
  parameter int CNTW      = $clog2(DELAY_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sched_i,
  input  logic       dir_wr_i,
  input  logic [7:0] dir_wdata_i,
  output logic       irq_o
);
  logic [7:0]      dir_q;
  logic [CNTW-1:0] cnt_q;
  logic            dir_ff;

  assign dir_ff = (dir_q == DIR_ALL_OUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_ALL_OUT;
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (dir_wr_i) dir_q <= dir_wdata_i;
      irq_o <= (sched_i && dir_ff) || (cnt_q == CNTW'(1));
      if (sched_i && !dir_ff)   cnt_q <= CNTW'(DELAY_CYC);  // restart on new request
      else if (cnt_q != '0)     cnt_q <= cnt_q - CNTW'(1);
    end
  end

  AST_IRQ_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sched_i && dir_ff) |=> irq_o);  // R10
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNTW'(DELAY_CYC));  // R10
  AST_DELAY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q > CNTW'(1)) && !(sched_i && dir_ff)) |=> !irq_o);  // R10
endmodule

// File: rtl/hs_handshake_ctl.sv
module hs_handshake_ctl
  import hs_link_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pb_wr_i,
  input  logic [7:0]    pb_wdata_i,
  input  logic          shift_out_i,
  input  logic          sr_wr_i,
  input  logic [7:0]    sr_wdata_i,
  input  logic          dh_commit_i,
  input  logic [CW-1:0] dh_len_i,
  input  logic [7:0]    dh_byte_i,
  output logic [AW-1:0] dh_raddr_o,
  output logic          hd_we_o,
  output logic [AW-1:0] hd_waddr_o,
  output logic [7:0]    hd_wdata_o,
  output logic [7:0]    pb_o,
  output logic [7:0]    sr_o,
  output logic [CW-1:0] hd_len_o,
  output logic          done_o,
  output logic          sched_o
);
  byte_t         b_q, b_nx, sr_q, sr_nx;
  logic [CW-1:0] hd_idx_q, hd_idx_nx, dh_idx_q, dh_idx_nx;
  logic [CW-1:0] dh_len_q, dh_len_nx, hd_len_q, hd_len_nx;
  logic          done_q, done_nx, pair_chg, dh_left;

  assign pair_chg = pb_wdata_i[TIP_BIT:TACK_BIT] != b_q[TIP_BIT:TACK_BIT];
  assign dh_left  = dh_idx_q < dh_len_q;

  always_comb begin
    b_nx      = b_q;
    sr_nx     = sr_q;
    hd_idx_nx = hd_idx_q;
    dh_idx_nx = dh_idx_q;
    dh_len_nx = dh_len_q;
    hd_len_nx = hd_len_q;
    done_nx   = 1'b0;
    hd_we_o   = 1'b0;
    sched_o   = 1'b0;
    if (sr_wr_i) sr_nx = sr_wdata_i;
    if (pb_wr_i) begin
      b_nx = pb_wdata_i;
      if (!pb_wdata_i[TIP_BIT]) begin
        if (shift_out_i) begin
          if (pair_chg && (hd_idx_q < CW'(DEPTH))) begin
            hd_we_o   = 1'b1;
            hd_idx_nx = hd_idx_q + CW'(1);
            sched_o   = 1'b1;
          end
        end else if (pair_chg && dh_left) begin
          sr_nx     = dh_byte_i;
          dh_idx_nx = dh_idx_q + CW'(1);
          if ((dh_idx_q + CW'(1)) >= dh_len_q) b_nx[TREQ_BIT] = 1'b1;
          sched_o   = 1'b1;
        end
      end else if (b_q[TIP_BIT] && (pb_wdata_i[TACK_BIT] != b_q[TACK_BIT])) begin
        // idle sync: request line tracks acknowledge
        b_nx[TREQ_BIT] = pb_wdata_i[TACK_BIT];
        sched_o        = 1'b1;
      end else begin
        if (!b_q[TIP_BIT]) begin
          done_nx   = (hd_idx_q != '0);
          if (hd_idx_q != '0) hd_len_nx = hd_idx_q;
          hd_idx_nx = '0;
          sched_o   = 1'b1;
        end
        if (dh_left) b_nx[TREQ_BIT] = 1'b0;
      end
    end else if (dh_commit_i) begin
      dh_len_nx = dh_len_i;
      dh_idx_nx = '0;
      sched_o   = 1'b1;
      if (b_q[TIP_BIT] && (dh_len_i != '0)) b_nx[TREQ_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q      <= '0;
      sr_q     <= '0;
      hd_idx_q <= '0;
      dh_idx_q <= '0;
      dh_len_q <= '0;
      hd_len_q <= '0;
      done_q   <= 1'b0;
    end else begin
      b_q      <= b_nx;
      sr_q     <= sr_nx;
      hd_idx_q <= hd_idx_nx;
      dh_idx_q <= dh_idx_nx;
      dh_len_q <= dh_len_nx;
      hd_len_q <= hd_len_nx;
      done_q   <= done_nx;
    end
  end

  assign dh_raddr_o = dh_idx_q[AW-1:0];
  assign hd_waddr_o = hd_idx_q[AW-1:0];
  assign hd_wdata_o = sr_q;
  assign pb_o       = b_q;
  assign sr_o       = sr_q;
  assign hd_len_o   = hd_len_q;
  assign done_o     = done_q;

  AST_HD_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_idx_q <= CW'(DEPTH));  // R4
  AST_DH_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dh_idx_q <= dh_len_q);  // R6
  AST_LAST_BYTE_TREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pb_wr_i && !pb_wdata_i[TIP_BIT] && !shift_out_i && pair_chg &&
     ((dh_idx_q + CW'(1)) == dh_len_q)) |=> pb_o[TREQ_BIT]);  // R6
  AST_DONE_HAS_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hd_len_o != '0));  // R5
  AST_SYNC_TREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pb_wr_i && pb_wdata_i[TIP_BIT] && b_q[TIP_BIT] &&
     (pb_wdata_i[TACK_BIT] != b_q[TACK_BIT]))
    |=> (pb_o[TREQ_BIT] == $past(pb_wdata_i[TACK_BIT])));  // R7
endmodule

// File: rtl/hs_link_engine.sv
module hs_link_engine #(
  parameter int DEPTH    = 16,
  parameter int CLK_HZ   = 200_000_000,
  parameter int DELAY_US = 300,
  parameter int AW       = $clog2(DEPTH),
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pb_wr_i,
  input  logic [7:0]    pb_wdata_i,
  output logic [7:0]    pb_o,
  input  logic          dirb_wr_i,
  input  logic [7:0]    dirb_wdata_i,
  input  logic          shift_out_i,
  input  logic          sr_wr_i,
  input  logic [7:0]    sr_wdata_i,
  output logic [7:0]    sr_o,
  input  logic          dh_wr_i,
  input  logic [AW-1:0] dh_waddr_i,
  input  logic [7:0]    dh_wdata_i,
  input  logic          dh_commit_i,
  input  logic [CW-1:0] dh_len_i,
  input  logic [AW-1:0] hd_raddr_i,
  output logic [7:0]    hd_rdata_o,
  output logic [CW-1:0] hd_len_o,
  output logic          pkt_done_o,
  output logic          sr_irq_o
);
  localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;

  logic [AW-1:0] dh_raddr, hd_waddr;
  logic [7:0]    dh_byte, hd_wdata;
  logic          hd_we, sched;

  hs_handshake_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pb_wr_i     (pb_wr_i),
    .pb_wdata_i  (pb_wdata_i),
    .shift_out_i (shift_out_i),
    .sr_wr_i     (sr_wr_i),
    .sr_wdata_i  (sr_wdata_i),
    .dh_commit_i (dh_commit_i),
    .dh_len_i    (dh_len_i),
    .dh_byte_i   (dh_byte),
    .dh_raddr_o  (dh_raddr),
    .hd_we_o     (hd_we),
    .hd_waddr_o  (hd_waddr),
    .hd_wdata_o  (hd_wdata),
    .pb_o        (pb_o),
    .sr_o        (sr_o),
    .hd_len_o    (hd_len_o),
    .done_o      (pkt_done_o),
    .sched_o     (sched)
  );

  hs_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_hd_ram (
    .clk_i   (clk_i),
    .we_i    (hd_we),
    .waddr_i (hd_waddr),
    .wdata_i (hd_wdata),
    .raddr_i (hd_raddr_i),
    .rdata_o (hd_rdata_o)
  );

  hs_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_dh_ram (
    .clk_i   (clk_i),
    .we_i    (dh_wr_i),
    .waddr_i (dh_waddr_i),
    .wdata_i (dh_wdata_i),
    .raddr_i (dh_raddr),
    .rdata_o (dh_byte)
  );

  hs_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sched_i     (sched),
    .dir_wr_i    (dirb_wr_i),
    .dir_wdata_i (dirb_wdata_i),
    .irq_o       (sr_irq_o)
  );
endmodule

// File: tb/tb_hs_link_engine.sv
`timescale 1ns/1ps
module tb_hs_link_engine;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int D  = 20;  // 1 MHz count base x 20 us

  logic clk = 1'b0, rst_n = 1'b0;
  logic pb_wr = 0, dirb_wr = 0, shift_out = 0, sr_wr = 0, dh_wr = 0, dh_commit = 0;
  logic [7:0] pb_wdata = 0, dirb_wdata = 0, sr_wdata = 0, dh_wdata = 0;
  logic [AW-1:0] dh_waddr = 0, hd_raddr = 0;
  logic [CW-1:0] dh_len = 0;
  logic [7:0] pb_o, sr_o, hd_rdata;
  logic [CW-1:0] hd_len;
  logic pkt_done, sr_irq;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  bit dir_ff = 1'b1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_link_engine #(.DEPTH(DEPTH), .CLK_HZ(1_000_000), .DELAY_US(D)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pb_wr_i(pb_wr), .pb_wdata_i(pb_wdata), .pb_o(pb_o),
    .dirb_wr_i(dirb_wr), .dirb_wdata_i(dirb_wdata),
    .shift_out_i(shift_out),
    .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata), .sr_o(sr_o),
    .dh_wr_i(dh_wr), .dh_waddr_i(dh_waddr), .dh_wdata_i(dh_wdata),
    .dh_commit_i(dh_commit), .dh_len_i(dh_len),
    .hd_raddr_i(hd_raddr), .hd_rdata_o(hd_rdata), .hd_len_o(hd_len),
    .pkt_done_o(pkt_done), .sr_irq_o(sr_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard driver side: expected cycle of the interrupt pulse
  task automatic push_irq(input int k);
    int t, i;
    if (dir_ff) t = k;
    else begin
      while (exp_q.size() > 0 && exp_q[$] > k) void'(exp_q.pop_back());
      t = k + D;
    end
    i = 0;
    while (i < exp_q.size() && exp_q[i] < t) i++;
    exp_q.insert(i, t);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (rst_n && sr_irq) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: actual pulse at cycle %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R10: actual pulse at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic pb_write(input logic [7:0] v, input bit irq);
    @(negedge clk);
    pb_wr = 1; pb_wdata = v;
    if (irq) push_irq(cyc + 1);
    @(negedge clk);
    pb_wr = 0;
  endtask

  task automatic sr_write(input logic [7:0] v);
    @(negedge clk); sr_wr = 1; sr_wdata = v;
    @(negedge clk); sr_wr = 0;
  endtask

  task automatic dir_write(input logic [7:0] v);
    @(negedge clk); dirb_wr = 1; dirb_wdata = v;
    @(negedge clk); dirb_wr = 0; dir_ff = (v == 8'hFF);
  endtask

  task automatic dh_fill(input int a, input logic [7:0] v);
    @(negedge clk); dh_wr = 1; dh_waddr = AW'(a); dh_wdata = v;
    @(negedge clk); dh_wr = 0;
  endtask

  task automatic commit(input int n);
    @(negedge clk); dh_commit = 1; dh_len = CW'(n);
    push_irq(cyc + 1);
    @(negedge clk); dh_commit = 0;
  endtask

  task automatic hd_read(input int a, input int exp, input string req);
    hd_raddr = AW'(a); #1;
    chk(req, hd_rdata, exp);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", pb_o, 0); chk("R1", sr_o, 0); chk("R1", hd_len, 0);
    chk("R1", pkt_done, 0); chk("R1", sr_irq, 0);
    rst_n = 1;
    // R5/R11: TIP rises from reset value, no bytes; immediate irq
    pb_write(8'h30, 1);
    chk("R5", pkt_done, 0); chk("R2", pb_o, 8'h30);

    // R3 host-to-device capture
    shift_out = 1;
    sr_write(8'hA1); pb_write(8'h10, 1);
    sr_write(8'hA2); pb_write(8'h00, 1);
    sr_write(8'hA3); pb_write(8'h00, 0);  // no pair change
    pb_write(8'h10, 1);
    pb_write(8'h30, 1);
    chk("R5", pkt_done, 1); chk("R5", hd_len, 3);
    @(negedge clk); chk("R5", pkt_done, 0);
    hd_read(0, 8'hA1, "R3"); hd_read(1, 8'hA2, "R3"); hd_read(2, 8'hA3, "R3");

    // R4 overflow
    for (int i = 0; i < 18; i++) begin
      sr_write(8'(8'h40 + i));
      pb_write((i % 2 == 0) ? 8'h10 : 8'h00, i < DEPTH);
    end
    pb_write(8'h30, 1);
    chk("R4", hd_len, DEPTH); chk("R4", pkt_done, 1);
    hd_read(0, 8'h40, "R4"); hd_read(15, 8'h4F, "R4");

    // R7 idle sync
    pb_write(8'h20, 1); chk("R7", pb_o, 8'h20);
    pb_write(8'h30, 1); chk("R7", pb_o, 8'h38);
    pb_write(8'h38, 0); chk("R7", pb_o, 8'h38);

    // delayed interrupts from here
    dir_write(8'h00);
    shift_out = 0;
    dh_fill(0, 8'hC0); dh_fill(1, 8'hC1); dh_fill(2, 8'hC2);
    commit(3); chk("R8", pb_o, 8'h30);
    pb_write(8'h10, 1); chk("R6", sr_o, 8'hC0);
    pb_write(8'h00, 1); chk("R6", sr_o, 8'hC1);
    pb_write(8'h10, 1); chk("R6", sr_o, 8'hC2); chk("R6", pb_o, 8'h18);
    pb_write(8'h00, 0); chk("R6", sr_o, 8'hC2); chk("R6", pb_o, 8'h00);
    pb_write(8'h30, 1); chk("R5", pkt_done, 0); chk("R6", pb_o, 8'h30);

    // R8 TIP rising with bytes left, R9 commit rewinds
    pb_write(8'h38, 0);
    dh_fill(0, 8'hD0); dh_fill(1, 8'hD1);
    commit(2); chk("R8", pb_o, 8'h30);
    pb_write(8'h10, 1); chk("R9", sr_o, 8'hD0);
    pb_write(8'h38, 1); chk("R8", pb_o, 8'h30);
    commit(2);
    pb_write(8'h10, 1); chk("R9", sr_o, 8'hD0);
    pb_write(8'h30, 1);

    repeat (D + 5) @(negedge clk);
    chk("R10", exp_q.size(), 0);
    dir_write(8'hFF);
    pb_write(8'h20, 1);
    repeat (4) @(negedge clk);
    chk("R10", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule